// File: doc/BRIEF.md
# Received-Word Packet Grouper

This block takes the stream of data words coming out of a serial receiver and groups them into packets. Two termination rules can be enabled on their own or together: a delimiter match, which closes the packet on a word equal to a configured value, and a length limit, which closes it once a configured number of words has been collected. When both are enabled, the packet closes on whichever rule fires first. A delimiter word stays in the packet it closes, as its last word.

Each accepted word leaves through a one-entry registered output with valid/ready handshaking. The output carries start-of-packet and end-of-packet markers and the word's 1-based position in its packet, so on the end-of-packet beat the position is the packet length. When both rules are disabled, words pass through unchanged with no markers. A word that arrives while the output is stalled is dropped and sets a sticky overflow flag.

Top module: `pkt_grouper`

## Requirements
- R1: After reset, out_valid_o and overflow_o are 0 and the first accepted word is treated as the start of a new packet.
- R2: With delim_en_i=0 and max_len_en_i=0, every accepted word is presented with out_sop_o=0, out_eop_o=0 and out_len_o=0.
- R3: With delim_en_i=1, an accepted word equal to delim_i closes the packet: that word is output with out_eop_o=1 and counts toward the length. With delim_en_i=0, the value of delim_i has no effect.
- R4: With max_len_en_i=1, the word whose 1-based position equals max_len_i is output with out_eop_o=1. A max_len_i of 0 behaves as 1, so every word is a one-word packet.
- R5: With both rules enabled, the packet closes on the first word that meets either rule.
- R6: While grouping is active, the first word of each packet has out_sop_o=1, and out_len_o gives the word's 1-based position in its packet (the packet length on the out_eop_o beat). The position saturates at 2^LEN_W-1.
- R7: The word accepted after an end-of-packet word starts a new packet: out_sop_o=1 and out_len_o=1.
- R8: An accepted word appears on the output one clock after it is accepted. While out_valid_o=1 and out_ready_i=0, out_valid_o and the whole output beat stay unchanged.
- R9: A word_valid_i pulse while out_valid_o=1 and out_ready_i=0 drops that word. The drop sets overflow_o, which stays 1 until reset, and the dropped word does not advance the packet position.
- R10: The delimiter compare covers all DATA_W bits, so a word that differs from delim_i only in its top bit (bit 8 at the default width) does not close the packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| word_i | input | DATA_W | Received data word |
| word_valid_i | input | 1 | word_i is valid this cycle |
| delim_i | input | DATA_W | Delimiter value |
| delim_en_i | input | 1 | Enables delimiter termination |
| max_len_i | input | LEN_W | Maximum words per packet |
| max_len_en_i | input | 1 | Enables length termination |
| out_valid_o | output | 1 | Output beat valid |
| out_ready_i | input | 1 | Downstream accepts the beat |
| out_word_o | output | DATA_W | Output data word |
| out_sop_o | output | 1 | First word of a packet |
| out_eop_o | output | 1 | Last word of a packet |
| out_len_o | output | LEN_W | 1-based position in packet; the packet length on the end beat |
| overflow_o | output | 1 | Sticky: a word was dropped while the output was stalled |

## Verification
Every result of this block arrives through the single output register, one clock after the edge that accepts the word. The bench therefore raises word_valid_i on a falling edge, lets exactly one rising edge pass, and compares the beat and its markers on the next falling edge. During a stall, the held beat and the overflow flag are compared on later falling edges, after several rising edges have passed with ready low. The dropped word's effect on the packet position is checked one accepted word later.

// File: rtl/pkt_grouper_pkg.sv
package pkt_grouper_pkg;
  typedef enum logic [1:0] {
    MODE_PASS  = 2'b00,
    MODE_DELIM = 2'b01,
    MODE_LEN   = 2'b10,
    MODE_BOTH  = 2'b11
  } grp_mode_e;
endpackage

// File: rtl/grp_term_detect.sv
module grp_term_detect
  import pkt_grouper_pkg::*;
#(
  parameter int DATA_W = 9,
  parameter int LEN_W  = 8
) (
  input  logic [DATA_W-1:0] word_i,
  input  logic [DATA_W-1:0] delim_i,
  input  logic              delim_en_i,
  input  logic [LEN_W-1:0]  max_len_i,
  input  logic              max_len_en_i,
  input  logic [LEN_W-1:0]  len_next_i,
  output logic              active_o,
  output logic              close_o
);
  grp_mode_e mode;
  logic      hit_delim;
  logic      hit_len;

  assign mode      = grp_mode_e'({max_len_en_i, delim_en_i});
  assign hit_delim = (word_i == delim_i);
  // len_next >= 1 always, so max_len of 0 acts as 1
  assign hit_len   = (len_next_i >= max_len_i);

  always_comb begin
    active_o = 1'b1;
    close_o  = 1'b0;
    unique case (mode)
      MODE_PASS:  active_o = 1'b0;
      MODE_DELIM: close_o  = hit_delim;
      MODE_LEN:   close_o  = hit_len;
      MODE_BOTH:  close_o  = hit_delim | hit_len;
      default:    active_o = 1'b0;
    endcase
  end

  always_comb begin
    if (!active_o) a_r2_no_close_in_pass: assert (!close_o);
  end
endmodule

// File: rtl/grp_len_counter.sv
module grp_len_counter #(
  parameter int LEN_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             accept_i,
  input  logic             active_i,
  input  logic             close_i,
  output logic [LEN_W-1:0] len_next_o,
  output logic             empty_o
);
  localparam logic [LEN_W-1:0] LenMax = '1;

  logic [LEN_W-1:0] cnt_q;

  assign len_next_o = (cnt_q == LenMax) ? cnt_q : cnt_q + 1'b1;
  assign empty_o    = (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (accept_i && active_i) begin
      cnt_q <= close_i ? '0 : len_next_o;
    end
  end

  a_r7_restart_after_close: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept_i && active_i && close_i) |=> empty_o);

  a_r9_hold_without_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !accept_i |=> $stable(cnt_q));
endmodule

// File: rtl/grp_out_stage.sv
module grp_out_stage #(
  parameter int PW = 19
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [PW-1:0] data_i,
  input  logic          drop_i,
  input  logic          ready_i,
  output logic          valid_o,
  output logic [PW-1:0] data_o,
  output logic          overflow_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      data_o  <= '0;
    end else if (load_i) begin
      valid_o <= 1'b1;
      data_o  <= data_i;
    end else if (ready_i) begin
      valid_o <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     overflow_o <= 1'b0;
    else if (drop_i) overflow_o <= 1'b1;
  end

  a_r8_stall_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !ready_i) |=> (valid_o && $stable(data_o)));

  a_r9_overflow_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overflow_o |=> overflow_o);

  a_r8_load_shows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> valid_o);
endmodule

// File: rtl/pkt_grouper.sv
module pkt_grouper #(
  parameter int DATA_W = 9,
  parameter int LEN_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] word_i,
  input  logic              word_valid_i,
  input  logic [DATA_W-1:0] delim_i,
  input  logic              delim_en_i,
  input  logic [LEN_W-1:0]  max_len_i,
  input  logic              max_len_en_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [DATA_W-1:0] out_word_o,
  output logic              out_sop_o,
  output logic              out_eop_o,
  output logic [LEN_W-1:0]  out_len_o,
  output logic              overflow_o
);
  localparam int PW = DATA_W + LEN_W + 2;

  logic             stall, accept, drop;
  logic             active, close, empty;
  logic [LEN_W-1:0] len_next;
  logic [PW-1:0]    beat_d, beat_q;

  assign stall  = out_valid_o & ~out_ready_i;
  assign accept = word_valid_i & ~stall;
  assign drop   = word_valid_i & stall;

  grp_term_detect #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_term (
    .word_i       (word_i),
    .delim_i      (delim_i),
    .delim_en_i   (delim_en_i),
    .max_len_i    (max_len_i),
    .max_len_en_i (max_len_en_i),
    .len_next_i   (len_next),
    .active_o     (active),
    .close_o      (close)
  );

  grp_len_counter #(.LEN_W(LEN_W)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .accept_i   (accept),
    .active_i   (active),
    .close_i    (close),
    .len_next_o (len_next),
    .empty_o    (empty)
  );

  assign beat_d = {word_i,
                   active & empty,
                   close,
                   active ? len_next : {LEN_W{1'b0}}};

  grp_out_stage #(.PW(PW)) u_out (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (accept),
    .data_i     (beat_d),
    .drop_i     (drop),
    .ready_i    (out_ready_i),
    .valid_o    (out_valid_o),
    .data_o     (beat_q),
    .overflow_o (overflow_o)
  );

  assign {out_word_o, out_sop_o, out_eop_o, out_len_o} = beat_q;

  a_r6_sop_is_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && out_sop_o) |-> (out_len_o == LEN_W'(1)));

  a_r6_eop_has_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && out_eop_o) |-> (out_len_o != '0));
endmodule

// File: tb/pkt_grouper_tb.sv
module pkt_grouper_tb;
  localparam int DATA_W = 9;
  localparam int LEN_W  = 8;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic [DATA_W-1:0] word_i = '0;
  logic              word_valid_i = 1'b0;
  logic [DATA_W-1:0] delim_i = '0;
  logic              delim_en_i = 1'b0;
  logic [LEN_W-1:0]  max_len_i = '0;
  logic              max_len_en_i = 1'b0;
  logic              out_valid_o;
  logic              out_ready_i = 1'b1;
  logic [DATA_W-1:0] out_word_o;
  logic              out_sop_o, out_eop_o;
  logic [LEN_W-1:0]  out_len_o;
  logic              overflow_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  pkt_grouper #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .word_i(word_i), .word_valid_i(word_valid_i),
    .delim_i(delim_i), .delim_en_i(delim_en_i), .max_len_i(max_len_i),
    .max_len_en_i(max_len_en_i), .out_valid_o(out_valid_o), .out_ready_i(out_ready_i),
    .out_word_o(out_word_o), .out_sop_o(out_sop_o), .out_eop_o(out_eop_o),
    .out_len_o(out_len_o), .overflow_o(overflow_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // drive one word, let one rising edge pass, check the beat at the next falling edge
  task automatic push(input string req, input logic [DATA_W-1:0] w,
                      input bit sop, input bit eop, input int len);
    @(negedge clk);
    word_i = w;
    word_valid_i = 1'b1;
    @(negedge clk);
    word_valid_i = 1'b0;
    chk({req, " valid"}, int'(out_valid_o), 1);
    chk({req, " word"},  int'(out_word_o), int'(w));
    chk({req, " sop"},   int'(out_sop_o), int'(sop));
    chk({req, " eop"},   int'(out_eop_o), int'(eop));
    chk({req, " len"},   int'(out_len_o), len);
  endtask

  task automatic cfg(input bit d_en, input int d, input bit l_en, input int l);
    @(negedge clk);
    delim_en_i = d_en;
    delim_i = DATA_W'(d);
    max_len_en_i = l_en;
    max_len_i = LEN_W'(l);
  endtask

  task automatic t_reset;
    chk("R1 valid after reset", int'(out_valid_o), 0);
    chk("R1 overflow after reset", int'(overflow_o), 0);
  endtask

  task automatic t_pass;
    // delim_i holds a matching value while disabled: must be ignored (R3)
    cfg(0, 'h1A5, 0, 1);
    push("R2 pass", 9'h1A5, 0, 0, 0);
    push("R2 pass", 9'h003, 0, 0, 0);
    @(negedge clk);
    chk("R8 valid drops with ready", int'(out_valid_o), 0);
  endtask

  task automatic t_first_packet;
    cfg(1, 'h0AA, 0, 0);
    push("R1 first word sop", 9'h011, 1, 0, 1);
    push("R3 delim", 9'h022, 0, 0, 2);
    push("R3 delim close", 9'h0AA, 0, 1, 3);
    push("R7 restart", 9'h033, 1, 0, 1);
    push("R3 delim close", 9'h0AA, 0, 1, 2);
  endtask

  task automatic t_full_width;
    cfg(1, 'h0AA, 0, 0);
    push("R10 top bit differs", 9'h1AA, 1, 0, 1);
    push("R10 exact match", 9'h0AA, 0, 1, 2);
  endtask

  task automatic t_len;
    cfg(0, 'h0AA, 1, 3);
    push("R4 len", 9'h0AA, 1, 0, 1);
    push("R4 len", 9'h0AA, 0, 0, 2);
    push("R4 len close", 9'h0AA, 0, 1, 3);
    push("R7 restart", 9'h001, 1, 0, 1);
    push("R4 len", 9'h002, 0, 0, 2);
    push("R4 len close", 9'h003, 0, 1, 3);
  endtask

  task automatic t_both;
    cfg(1, 'h055, 1, 4);
    push("R5 both", 9'h001, 1, 0, 1);
    push("R5 both", 9'h002, 0, 0, 2);
    push("R5 delim first", 9'h055, 0, 1, 3);
    push("R5 both", 9'h001, 1, 0, 1);
    push("R5 both", 9'h002, 0, 0, 2);
    push("R5 both", 9'h003, 0, 0, 3);
    push("R5 len first", 9'h004, 0, 1, 4);
  endtask

  task automatic t_len_zero;
    cfg(0, 0, 1, 0);
    push("R4 max zero", 9'h100, 1, 1, 1);
    push("R4 max zero", 9'h101, 1, 1, 1);
  endtask

  task automatic t_stall;
    cfg(0, 0, 1, 3);
    @(negedge clk);
    out_ready_i = 1'b0;
    push("R8 stall load", 9'h0A1, 1, 0, 1);
    @(negedge clk);
    word_i = 9'h0B2;
    word_valid_i = 1'b1;
    @(negedge clk);
    word_valid_i = 1'b0;
    chk("R9 overflow set", int'(overflow_o), 1);
    chk("R8 held valid", int'(out_valid_o), 1);
    chk("R8 held word", int'(out_word_o), 'h0A1);
    chk("R8 held len", int'(out_len_o), 1);
    repeat (3) @(negedge clk);
    chk("R8 still held", int'(out_word_o), 'h0A1);
    out_ready_i = 1'b1;
    @(negedge clk);
    chk("R8 released", int'(out_valid_o), 0);
    push("R9 dropped not counted", 9'h0C3, 0, 0, 2);
    push("R9 close", 9'h0D4, 0, 1, 3);
    chk("R9 overflow sticky", int'(overflow_o), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_pass();
    t_first_packet();
    t_full_width();
    t_len();
    t_both();
    t_len_zero();
    t_stall();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule